// File: doc/BRIEF.md
# Burst Data Gating with Clock-Enable Suspend

This block sits in the data path of a synchronous DRAM style memory port and decides, cycle by cycle, whether a burst beat moves. A burst opens with a start pulse that carries the beat count and the transfer direction. While the burst runs, every rising edge with the clock enable high transfers one beat and advances a beat index. On writes the block produces one write strobe per byte of a 96-bit bus, gated with no delay by two mask inputs. The lower mask covers the low byte of each 16-bit lane and the upper mask covers the high byte. On reads it produces a hold signal that tells the output stage to keep the present data.

Pulling the clock enable low freezes the burst at the next edge. No beat moves, no strobe fires and the index stays put. When the enable comes back high, the edge that first sees it high is still frozen, and the burst continues from the stopped beat at the edge after that. A done pulse marks the edge that moves the final beat.

The control is a three-state machine:
- `ST_IDLE` goes to `ST_ACTIVE` on a start pulse seen with the enable high. This is the "open" transition.
- `ST_ACTIVE` stays in `ST_ACTIVE` on a non-final beat ("advance"). It returns to `ST_IDLE` on the final beat ("close"). It goes to `ST_FROZEN` when the enable is low ("suspend").
- `ST_FROZEN` stays in `ST_FROZEN` while the enable is low ("stay"). It goes to `ST_ACTIVE` once the enable is high ("rearm"). The first beat after rearming moves one edge later.

Top module: `burst_gate_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `beat_valid`, `burst_done` and `rd_hold` are 0, `beat_idx` is 0 and every `byte_wen` bit is 0.
- R2: A start pulse is accepted only when idle and with `cke` high at the same edge. The burst then moves `len`+1 beats (`len` 0 means 1 beat, 15 means 16 beats). The first beat can move at the edge after the start.
- R3: `byte_wen[b]` is high exactly when a write beat moves at this edge and the byte's mask is low. Even bytes b (data bits 16k..16k+7) use `mask_lo`. Odd bytes (bits 16k+8..16k+15) use `mask_hi`. The mask acts at the same edge, with zero latency.
- R4: The masks may change on any cycle of a write burst, and each beat uses only the mask values present at its own edge.
- R5: At an edge of an open burst where `cke` is low, no beat moves: `beat_valid` and all `byte_wen` are 0, and `beat_idx` keeps its value.
- R6: After a suspension, the first edge with `cke` high moves no beat. The next edge with `cke` high moves the beat at the index where the burst stopped.
- R7: `burst_done` is high only at the edge that moves the final beat. The block is idle after that edge and `beat_idx` returns to 0.
- R8: In a read burst every `byte_wen` bit is 0. `rd_hold` is high on every edge of the open read burst that moves no beat, and it is 0 otherwise.
- R9: A start pulse while a burst is open is ignored. The running burst keeps its length, direction and index.
- R10: A mask applied on a suspended cycle has no effect. No strobe fires, and the next moving beat uses only the mask present at its own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Burst open request |
| len | input | 4 | Beats in the burst minus one |
| dir_wr | input | 1 | 1 for a write burst, 0 for a read burst |
| cke | input | 1 | Clock enable; low suspends the burst |
| mask_lo | input | 1 | Mask for the low byte of each 16-bit lane |
| mask_hi | input | 1 | Mask for the high byte of each 16-bit lane |
| byte_wen | output | 12 | Per-byte write strobe for the current edge |
| beat_valid | output | 1 | A beat moves at this edge |
| beat_idx | output | 4 | Index of the beat due to move next |
| burst_done | output | 1 | The final beat moves at this edge |
| busy | output | 1 | A burst is open |
| rd_hold | output | 1 | Read data must be held at this edge |

## Verification
Write bursts are driven with a fresh mask pair on every beat, covering all four low/high combinations. This shows whether each mask reaches the right byte parity and whether it acts at the same edge rather than one edge late. The clock enable is dropped for one cycle and for several cycles, both mid-burst and on the cycle just before the final beat, while the masks toggle. These patterns separate a resume that comes one edge too early from a correct one, and they reveal an index or strobe that leaks through a frozen cycle. Read bursts with suspensions, start pulses sent into open bursts, the 1-beat and 16-beat lengths, and a long stretch of random stimulus are each compared with a behavioural model on every clock.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_FROZEN = 2'd2
    } bgc_state_e;

endpackage

// File: rtl/bgc_fsm.sv
module bgc_fsm
    import bgc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cke,
    input  logic       last_beat,
    output bgc_state_e state,
    output logic       load,
    output logic       beat
);

    bgc_state_e state_q;
    bgc_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        beat    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && cke) begin
                    load    = 1'b1;
                    state_d = ST_ACTIVE;          // open
                end
            end
            ST_ACTIVE: begin
                if (cke) begin
                    beat    = 1'b1;
                    state_d = last_beat ? ST_IDLE  // close
                                        : ST_ACTIVE; // advance
                end else begin
                    state_d = ST_FROZEN;          // suspend
                end
            end
            ST_FROZEN: begin
                state_d = cke ? ST_ACTIVE : ST_FROZEN; // rearm / stay
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/bgc_beat_ctr.sv
module bgc_beat_ctr #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic             wr_in,
    input  logic             beat,
    output logic [LEN_W-1:0] idx,
    output logic             last_beat,
    output logic             wr_q
);

    logic [LEN_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            len_q <= '0;
            wr_q  <= 1'b0;
        end else if (load) begin
            idx_q <= '0;
            len_q <= len_in;
            wr_q  <= wr_in;
        end else if (beat) begin
            idx_q <= last_beat ? '0 : idx_q + 1'b1;
        end
    end

    assign last_beat = (idx_q == len_q);
    assign idx       = idx_q;

endmodule

// File: rtl/bgc_strobe.sv
module bgc_strobe #(
    parameter int LANES = 6
) (
    input  logic               beat,
    input  logic               wr,
    input  logic               mask_lo,
    input  logic               mask_hi,
    output logic [2*LANES-1:0] byte_wen
);

    logic wr_beat;
    assign wr_beat = beat && wr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign byte_wen[2*g]   = wr_beat && !mask_lo;
        assign byte_wen[2*g+1] = wr_beat && !mask_hi;
    end

endmodule

// File: rtl/burst_gate_ctrl.sv
module burst_gate_ctrl
    import bgc_pkg::*;
#(
    parameter int DATA_W = 96,
    parameter int LEN_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [LEN_W-1:0]    len,
    input  logic                dir_wr,
    input  logic                cke,
    input  logic                mask_lo,
    input  logic                mask_hi,
    output logic [DATA_W/8-1:0] byte_wen,
    output logic                beat_valid,
    output logic [LEN_W-1:0]    beat_idx,
    output logic                burst_done,
    output logic                busy,
    output logic                rd_hold
);

    localparam int LANES  = DATA_W / 16;
    localparam int NBYTES = DATA_W / 8;

    bgc_state_e state;
    logic       load;
    logic       beat;
    logic       last_beat;
    logic       wr_q;

    bgc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cke       (cke),
        .last_beat (last_beat),
        .state     (state),
        .load      (load),
        .beat      (beat)
    );

    bgc_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .len_in    (len),
        .wr_in     (dir_wr),
        .beat      (beat),
        .idx       (beat_idx),
        .last_beat (last_beat),
        .wr_q      (wr_q)
    );

    bgc_strobe #(.LANES(LANES)) u_strobe (
        .beat     (beat),
        .wr       (wr_q),
        .mask_lo  (mask_lo),
        .mask_hi  (mask_hi),
        .byte_wen (byte_wen)
    );

    assign busy       = (state != ST_IDLE);
    assign beat_valid = beat;
    assign burst_done = beat && last_beat;
    assign rd_hold    = busy && !wr_q && !beat;

endmodule

// File: rtl/burst_gate_chk.sv
module burst_gate_chk #(
    parameter int NBYTES = 12,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic [NBYTES-1:0] byte_wen,
    input logic              beat_valid,
    input logic [LEN_W-1:0]  beat_idx,
    input logic              burst_done,
    input logic              busy,
    input logic              rd_hold
);

    assert_no_beat_when_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (!beat_valid && byte_wen == '0));

    assert_idx_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat_valid) |=> (beat_idx == $past(beat_idx)));

    assert_resume_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(cke)) |-> !beat_valid);

    assert_done_on_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> beat_valid);

    assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> (!busy && beat_idx == '0));

    assert_no_strobe_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hold |-> (byte_wen == '0));

    assert_strobe_needs_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wen != '0) |-> beat_valid);

endmodule

bind burst_gate_ctrl burst_gate_chk #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .byte_wen   (byte_wen),
    .beat_valid (beat_valid),
    .beat_idx   (beat_idx),
    .burst_done (burst_done),
    .busy       (busy),
    .rd_hold    (rd_hold)
);

// File: tb/tb_burst_gate_ctrl.sv
`timescale 1ns/1ps
module tb_burst_gate_ctrl;

    localparam int DATA_W = 96;
    localparam int LEN_W  = 4;
    localparam int NB     = DATA_W / 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] len = '0;
    logic             dir_wr = 1'b0;
    logic             cke = 1'b1;
    logic             mask_lo = 1'b0;
    logic             mask_hi = 1'b0;
    logic [NB-1:0]    byte_wen;
    logic             beat_valid;
    logic [LEN_W-1:0] beat_idx;
    logic             burst_done;
    logic             busy;
    logic             rd_hold;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    // behavioural model state
    bit m_busy = 0;
    bit m_frozen = 0;
    bit m_wr = 0;
    int m_len = 0;
    int m_idx = 0;

    always #5 clk = ~clk;

    burst_gate_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .len(len), .dir_wr(dir_wr),
        .cke(cke), .mask_lo(mask_lo), .mask_hi(mask_hi), .byte_wen(byte_wen),
        .beat_valid(beat_valid), .beat_idx(beat_idx), .burst_done(burst_done),
        .busy(busy), .rd_hold(rd_hold)
    );

    task automatic check(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // one clock: drive after falling edge, compare, advance model
    task automatic cyc(bit st, int ln, bit wr, bit ck, bit ml, bit mh);
        bit          e_beat;
        bit          e_last;
        logic [NB-1:0] e_wen;
        @(negedge clk);
        start = st; len = LEN_W'(ln); dir_wr = wr; cke = ck;
        mask_lo = ml; mask_hi = mh;
        #1;
        e_beat = m_busy && !m_frozen && ck;
        e_last = e_beat && (m_idx == m_len);
        for (int b = 0; b < NB; b++)
            e_wen[b] = e_beat && m_wr && !((b % 2 == 1) ? mh : ml);
        check("byte_wen",   int'(byte_wen),   int'(e_wen));
        check("beat_valid", int'(beat_valid), int'(e_beat));
        check("beat_idx",   int'(beat_idx),   m_idx);
        check("burst_done", int'(burst_done), int'(e_last));
        check("busy",       int'(busy),       int'(m_busy));
        check("rd_hold",    int'(rd_hold),    int'(m_busy && !m_wr && !e_beat));
        if (!m_busy) begin
            if (st && ck) begin
                m_busy = 1; m_frozen = 0; m_wr = wr; m_len = ln; m_idx = 0;
            end
        end else if (m_frozen) begin
            if (ck) m_frozen = 0;
        end else if (!ck) begin
            m_frozen = 1;
        end else if (m_idx == m_len) begin
            m_busy = 0; m_idx = 0;
        end else begin
            m_idx++;
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        cyc(0, 0, 0, 1, 0, 0);

        // R2: start with cke low is not taken
        cur_req = "R2";
        cyc(1, 2, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);

        // R3 R4 R7: write of 4 beats, masks walk all combinations
        cur_req = "R3";
        cyc(1, 3, 1, 1, 0, 0);
        cur_req = "R4";
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 0);
        cyc(0, 0, 0, 1, 0, 1);
        cur_req = "R7";
        cyc(0, 0, 0, 1, 1, 1);
        cyc(0, 0, 0, 1, 0, 0);

        // R5 R6 R10: write of 6 beats with suspensions and masks toggled while frozen
        cur_req = "R5";
        cyc(1, 5, 1, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cur_req = "R10";
        cyc(0, 0, 0, 0, 1, 1);
        cur_req = "R6";
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 1);
        cyc(0, 0, 0, 0, 0, 0);
        cur_req = "R10";
        cyc(0, 0, 0, 1, 1, 1);
        cur_req = "R6";
        cyc(0, 0, 0, 1, 1, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 1, 0, 0);
        cur_req = "R7";
        cyc(0, 0, 0, 1, 0, 1);
        cyc(0, 0, 0, 1, 0, 0);

        // R8 R9: read of 8 beats with a start sent into it and a suspension
        cur_req = "R8";
        cyc(1, 7, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cur_req = "R9";
        cyc(1, 1, 1, 1, 0, 0);
        cyc(1, 0, 1, 1, 1, 0);
        cur_req = "R8";
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, 0, 0);

        // R2 R7: shortest and longest bursts
        cur_req = "R2";
        cyc(1, 0, 1, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 1);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(1, 15, 1, 1, 0, 0);
        for (int i = 0; i < 17; i++) cyc(0, 0, 0, 1, i % 2, i % 3 == 0);

        // R4 R5 R6 R9: random stimulus
        cur_req = "R4";
        for (int i = 0; i < 600; i++) begin
            cyc(($urandom % 4) == 0, $urandom % 16, $urandom % 2,
                ($urandom % 4) != 0, $urandom % 2, $urandom % 2);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule